// File: doc/BRIEF.md
# CAN Controller Status Register with Status-Change Interrupt

This block holds the eight-bit status word that a CAN controller presents to its host processor, and turns selected changes in that word into a single status-change interrupt request. The protocol engine supplies three levels (bus-off, error-threshold and wake), two completion pulses (receive and transmit), and a three-bit last-error code with a load strobe. The processor reads the word through a read strobe and may write only the two completion bits.

Each bit has its own rule for which transition counts as a status change. A change sets an internal flag. Any processor read clears that flag. The same read also parks the error code at all-ones, so a later error code interrupts only after a fresh fault report. When the flag is set, the status interrupt is enabled and no other controller interrupt is pending, the block presents vector code 01h. In every other case it presents 00h.

The threshold bit has two modes, selected by an input. In the default mode only its rising edge counts. In the 128-count mode both of its edges count.

Top module: `can_stat_irq`

## Requirements
- R1: The status word is, from bit 7 down to bit 0: bus-off, error-threshold, wake, receive-ok, transmit-ok, then the error code in bits 2..0. After reset, the word, the flag and the vector are all zero.
- R2: Bits 7, 6 and 5 show the engine's bus-off, threshold and wake levels one clock later. A processor write does not change them, and it does not change the error code either.
- R3: A processor write loads receive-ok from data bit 4 and transmit-ok from data bit 3. A completion pulse sets its bit. If a pulse and a write fall in the same cycle, the pulse wins.
- R4: A processor read clears the status-change flag on the next clock. If a status change occurs in that same cycle, the flag stays set.
- R5: A processor read loads 111 into the error code. If an error report arrives in that same cycle, the reported code is loaded instead.
- R6: A 0-to-1 change of bus-off raises a status change. A 1-to-0 change does not.
- R7: When the mode input is 0, only a 0-to-1 change of the threshold bit raises a status change. When the mode input is 1, both directions do.
- R8: A 1-to-0 change of wake raises a status change. A 0-to-1 change does not.
- R9: An error report raises a status change only when the code currently held is 000 or 111 and the reported code is neither 000 nor 111.
- R10: A receive or transmit completion pulse raises a status change only when its ok bit is already 1.
- R11: The vector output is 01h when the flag is set, the enable is 1 and no other interrupt is pending. Otherwise it is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pe_bus_off | input | 1 | Bus-off level from the engine |
| pe_thr | input | 1 | Error-threshold level from the engine |
| pe_wake | input | 1 | Wake-status level from the engine |
| pe_rx_done | input | 1 | Receive completed pulse |
| pe_tx_done | input | 1 | Transmit completed pulse |
| pe_err_valid | input | 1 | Error-code load strobe |
| pe_err_code | input | 3 | Reported error code |
| thr_mode128 | input | 1 | 1 = both threshold edges interrupt |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| stat_ie | input | 1 | Status interrupt enable |
| no_other_pend | input | 1 | 1 = no other controller interrupt pending |
| stat_reg | output | 8 | Status word |
| stat_flag | output | 1 | Internal status-change flag |
| irq_vec | output | 8 | Interrupt vector code |

## Verification
The error-code rule is swept over all 64 pairs of held code and reported code. This separates the two idle codes from the six fault codes on both the source and the target side. Each of the three level bits is driven through all four old/new value pairs in both threshold modes, which shows exactly which direction of change is counted for each bit. The completion bits are tried with the bit preset to 0 and to 1, and together with a write in the same cycle. The vector is checked over all eight combinations of flag, enable and pending.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

  localparam int CODE_W = 3;
  localparam int REG_W  = 8;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_kind_e;

  // Bit positions in the status word; the host decodes this order.
  localparam int POS_BUS_OFF = 7;
  localparam int POS_THR     = 6;
  localparam int POS_WAKE    = 5;
  localparam int POS_RX      = 4;
  localparam int POS_TX      = 3;

  // Code value counts as "idle" when all zeros or all ones.
  function automatic logic code_idle(input logic [CODE_W-1:0] c);
    return (c == '0) || (c == '1);
  endfunction

  function automatic logic edge_hit(input edge_kind_e k, input logic prev, input logic cur);
    case (k)
      EDGE_RISE: return ~prev & cur;
      EDGE_FALL: return prev & ~cur;
      default:   return prev ^ cur;
    endcase
  endfunction

  function automatic logic code_event(input logic [CODE_W-1:0] held,
                                      input logic [CODE_W-1:0] fresh);
    return code_idle(held) && !code_idle(fresh);
  endfunction

endpackage

// File: rtl/cst_level_bits.sv
module cst_level_bits
  import can_stat_pkg::*;
#(
  parameter int N_LVL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] lvl_in,
  input  edge_kind_e       kind [N_LVL],
  output logic [N_LVL-1:0] lvl_q,
  output logic [N_LVL-1:0] lvl_ev
);

  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl_in[i];
    end
    assign lvl_ev[i] = rst_n && edge_hit(kind[i], lvl_q[i], lvl_in[i]);
  end

endmodule

// File: rtl/cst_done_bits.sv
module cst_done_bits #(
  parameter int N_DIR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DIR-1:0] done,
  input  logic             wr,
  input  logic [N_DIR-1:0] wbits,
  output logic [N_DIR-1:0] ok_q,
  output logic [N_DIR-1:0] ok_ev
);

  for (genvar i = 0; i < N_DIR; i++) begin : g_dir
    logic nxt;
    always_comb begin
      nxt = ok_q[i];
      if (wr)      nxt = wbits[i];
      if (done[i]) nxt = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) ok_q[i] <= 1'b0;
      else        ok_q[i] <= nxt;
    end
    assign ok_ev[i] = rst_n && done[i] && ok_q[i];
  end

endmodule

// File: rtl/cst_err_code.sv
module cst_err_code
  import can_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [CODE_W-1:0] err_code,
  input  logic              rd,
  output logic [CODE_W-1:0] code_q,
  output logic              code_ev
);

  logic [CODE_W-1:0] code_nxt;

  always_comb begin
    code_nxt = code_q;
    if (rd)        code_nxt = '1;
    if (err_valid) code_nxt = err_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_nxt;
  end

  assign code_ev = rst_n && err_valid && code_event(code_q, err_code);

endmodule

// File: rtl/cst_irq_flag.sv
module cst_irq_flag #(
  parameter int VEC_W    = 8,
  parameter int STAT_VEC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_any,
  input  logic             rd,
  input  logic             ie,
  input  logic             no_pend,
  output logic             flag_q,
  output logic [VEC_W-1:0] vec
);

  localparam logic [VEC_W-1:0] VEC_CODE = VEC_W'(STAT_VEC);

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (ev_any) flag_q <= 1'b1;
    else if (rd)     flag_q <= 1'b0;
  end

  assign vec = (flag_q && ie && no_pend) ? VEC_CODE : '0;

endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
  import can_stat_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int STAT_VEC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pe_bus_off,
  input  logic              pe_thr,
  input  logic              pe_wake,
  input  logic              pe_rx_done,
  input  logic              pe_tx_done,
  input  logic              pe_err_valid,
  input  logic [CODE_W-1:0] pe_err_code,
  input  logic              thr_mode128,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [REG_W-1:0]  cpu_wdata,
  input  logic              stat_ie,
  input  logic              no_other_pend,
  output logic [REG_W-1:0]  stat_reg,
  output logic              stat_flag,
  output logic [VEC_W-1:0]  irq_vec
);

  localparam int N_LVL = 3;
  localparam int N_DIR = 2;

  // Named internal events, visible to the bound checker.
  logic [N_LVL-1:0]  lvl_q, lvl_ev;
  logic [N_DIR-1:0]  ok_q, ok_ev;
  logic [CODE_W-1:0] code_q;
  logic              ev_bus_off, ev_thr, ev_wake, ev_rx, ev_tx, ev_err, ev_any;
  edge_kind_e        kinds [N_LVL];

  // Index 2: bus-off, 1: threshold, 0: wake
  assign kinds[2] = EDGE_RISE;
  assign kinds[1] = thr_mode128 ? EDGE_BOTH : EDGE_RISE;
  assign kinds[0] = EDGE_FALL;

  cst_level_bits #(.N_LVL(N_LVL)) u_lvl (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in ({pe_bus_off, pe_thr, pe_wake}),
    .kind   (kinds),
    .lvl_q  (lvl_q),
    .lvl_ev (lvl_ev)
  );

  cst_done_bits #(.N_DIR(N_DIR)) u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .done  ({pe_rx_done, pe_tx_done}),
    .wr    (cpu_wr),
    .wbits ({cpu_wdata[POS_RX], cpu_wdata[POS_TX]}),
    .ok_q  (ok_q),
    .ok_ev (ok_ev)
  );

  cst_err_code u_code (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (pe_err_valid),
    .err_code  (pe_err_code),
    .rd        (cpu_rd),
    .code_q    (code_q),
    .code_ev   (ev_err)
  );

  assign ev_bus_off = lvl_ev[2];
  assign ev_thr     = lvl_ev[1];
  assign ev_wake    = lvl_ev[0];
  assign ev_rx      = ok_ev[1];
  assign ev_tx      = ok_ev[0];
  assign ev_any     = ev_bus_off | ev_thr | ev_wake | ev_rx | ev_tx | ev_err;

  cst_irq_flag #(.VEC_W(VEC_W), .STAT_VEC(STAT_VEC)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_any  (ev_any),
    .rd      (cpu_rd),
    .ie      (stat_ie),
    .no_pend (no_other_pend),
    .flag_q  (stat_flag),
    .vec     (irq_vec)
  );

  assign stat_reg = {lvl_q, ok_q, code_q};

  // Write data bits other than the two ok bits have no destination.
  logic wdata_unused;
  assign wdata_unused = ^{cpu_wdata[7:5], cpu_wdata[2:0]};

endmodule

// File: rtl/can_stat_chk.sv
module can_stat_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pe_bus_off,
  input logic             pe_thr,
  input logic             pe_wake,
  input logic             pe_rx_done,
  input logic             pe_tx_done,
  input logic             pe_err_valid,
  input logic             cpu_rd,
  input logic             stat_ie,
  input logic             no_other_pend,
  input logic [7:0]       stat_reg,
  input logic             stat_flag,
  input logic [VEC_W-1:0] irq_vec,
  input logic             ev_any
);

  AST_LEVELS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_reg[7:5] == $past({pe_bus_off, pe_thr, pe_wake})); // R2
  AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pe_rx_done |=> stat_reg[4]); // R3
  AST_TX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pe_tx_done |=> stat_reg[3]); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !ev_any |=> !stat_flag); // R4
  AST_EVENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> stat_flag); // R4
  AST_READ_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !pe_err_valid |=> stat_reg[2:0] == 3'b111); // R5
  AST_BUS_OFF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_reg[7] && pe_bus_off |=> stat_flag); // R6
  AST_WAKE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reg[5] && !pe_wake |=> stat_flag); // R8
  AST_RX_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reg[4] && pe_rx_done |=> stat_flag); // R10
  AST_VEC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    stat_flag && stat_ie && no_other_pend |-> irq_vec == VEC_W'(1)); // R11
  AST_VEC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_flag |-> irq_vec == '0); // R11

endmodule

bind can_stat_irq can_stat_chk #(.VEC_W(VEC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pe_bus_off    (pe_bus_off),
  .pe_thr        (pe_thr),
  .pe_wake       (pe_wake),
  .pe_rx_done    (pe_rx_done),
  .pe_tx_done    (pe_tx_done),
  .pe_err_valid  (pe_err_valid),
  .cpu_rd        (cpu_rd),
  .stat_ie       (stat_ie),
  .no_other_pend (no_other_pend),
  .stat_reg      (stat_reg),
  .stat_flag     (stat_flag),
  .irq_vec       (irq_vec),
  .ev_any        (ev_any)
);

// File: tb/sim_can_stat_irq.sv
`timescale 1ns/1ps
module sim_can_stat_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pe_bus_off = 0, pe_thr = 0, pe_wake = 0;
  logic       pe_rx_done = 0, pe_tx_done = 0, pe_err_valid = 0;
  logic [2:0] pe_err_code = 0;
  logic       thr_mode128 = 0, cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0;
  logic       stat_ie = 0, no_other_pend = 0;
  logic [7:0] stat_reg;
  logic       stat_flag;
  logic [7:0] irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  can_stat_irq u0 (
    .clk(clk), .rst_n(rst_n),
    .pe_bus_off(pe_bus_off), .pe_thr(pe_thr), .pe_wake(pe_wake),
    .pe_rx_done(pe_rx_done), .pe_tx_done(pe_tx_done),
    .pe_err_valid(pe_err_valid), .pe_err_code(pe_err_code),
    .thr_mode128(thr_mode128), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .stat_ie(stat_ie), .no_other_pend(no_other_pend),
    .stat_reg(stat_reg), .stat_flag(stat_flag), .irq_vec(irq_vec)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    {pe_bus_off, pe_thr, pe_wake, pe_rx_done, pe_tx_done, pe_err_valid} = '0;
    pe_err_code = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic clear_flag();
    cpu_rd = 1; step(); cpu_rd = 0;
  endtask

  // Bench-side rule: a code is quiet if it equals 0 or 7.
  function automatic int quiet(input int c);
    return (c == 0 || c == 7) ? 1 : 0;
  endfunction

  // idx 0 bus-off, 1 threshold, 2 wake
  function automatic int lvl_expect(input int idx, input int p, input int n, input int m);
    if (idx == 0) return (p == 0 && n == 1) ? 1 : 0;
    if (idx == 1) return m ? ((p != n) ? 1 : 0) : ((p == 0 && n == 1) ? 1 : 0);
    return (p == 1 && n == 0) ? 1 : 0;
  endfunction

  task automatic set_lvl(input int idx, input logic v);
    if (idx == 0) pe_bus_off = v;
    else if (idx == 1) pe_thr = v;
    else pe_wake = v;
  endtask

  initial begin
    do_reset();
    chk(stat_reg, 0, "R1 reset word");
    chk(stat_flag, 0, "R1 reset flag");
    chk(irq_vec, 0, "R1 reset vector");

    // R2: read-only bits ignore writes
    cpu_wr = 1; cpu_wdata = 8'hE7; step(); cpu_wr = 0;
    chk(stat_reg, 8'h00, "R2 write to read-only bits");
    pe_bus_off = 1; pe_thr = 1; pe_wake = 1; step();
    chk(stat_reg[7:5], 3'b111, "R2 levels follow");

    // R3: write and pulse
    do_reset();
    cpu_wr = 1; cpu_wdata = 8'h10; step(); cpu_wr = 0;
    chk(stat_reg[4:3], 2'b10, "R3 write rx bit");
    cpu_wr = 1; cpu_wdata = 8'h08; step(); cpu_wr = 0;
    chk(stat_reg[4:3], 2'b01, "R3 write tx bit");
    cpu_wr = 1; cpu_wdata = 8'h00; pe_rx_done = 1; step();
    cpu_wr = 0; pe_rx_done = 0;
    chk(stat_reg[4:3], 2'b10, "R3 pulse beats write");

    // R10: completion with bit preset 0/1
    for (int dir = 0; dir < 2; dir++) begin
      for (int pre = 0; pre < 2; pre++) begin
        do_reset();
        cpu_wr = 1; cpu_wdata = 8'(pre << (dir ? 4 : 3)); step(); cpu_wr = 0;
        clear_flag();
        if (dir) pe_rx_done = 1; else pe_tx_done = 1;
        step();
        pe_rx_done = 0; pe_tx_done = 0;
        chk(stat_flag, pre, "R10 completion flag");
        chk(dir ? stat_reg[4] : stat_reg[3], 1, "R10 completion bit set");
      end
    end

    // R6 R7 R8: level sweeps in both modes
    for (int m = 0; m < 2; m++)
      for (int idx = 0; idx < 3; idx++)
        for (int p = 0; p < 2; p++)
          for (int n = 0; n < 2; n++) begin
            do_reset();
            thr_mode128 = m[0];
            set_lvl(idx, p[0]); step();
            clear_flag();
            set_lvl(idx, n[0]); step();
            chk(stat_flag, lvl_expect(idx, p, n, m),
                idx == 0 ? "R6 bus-off edge" : (idx == 1 ? "R7 threshold edge" : "R8 wake edge"));
            chk(stat_reg[7 - idx], n, "R2 level value");
          end
    thr_mode128 = 0;

    // R9: all 64 held/reported pairs
    for (int f = 0; f < 8; f++)
      for (int t = 0; t < 8; t++) begin
        do_reset();
        pe_err_valid = 1; pe_err_code = 3'(f); step();
        cpu_rd = 1; step();            // reload same code with a read: flag cleared
        cpu_rd = 0;
        chk(stat_flag, 0, "R9 setup flag clear");
        pe_err_code = 3'(t); step();
        pe_err_valid = 0;
        chk(stat_flag, (quiet(f) == 1 && quiet(t) == 0) ? 1 : 0, "R9 code change");
        chk(stat_reg[2:0], t, "R5 reported code wins over read");
      end

    // R5: read parks code at 111
    do_reset();
    pe_err_valid = 1; pe_err_code = 3'd3; step(); pe_err_valid = 0;
    chk(stat_reg[2:0], 3, "R5 code loaded");
    clear_flag();
    chk(stat_reg[2:0], 7, "R5 read parks code");
    chk(stat_flag, 0, "R4 read clears flag");
    pe_err_valid = 1; pe_err_code = 3'd5; step(); pe_err_valid = 0;
    chk(stat_flag, 1, "R9 fresh error after read");

    // R4: event and read in same cycle
    do_reset();
    pe_bus_off = 1; cpu_rd = 1; step(); cpu_rd = 0;
    chk(stat_flag, 1, "R4 event beats read");

    // R11: vector over flag x enable x pending
    for (int fl = 0; fl < 2; fl++) begin
      do_reset();
      if (fl) begin pe_bus_off = 1; step(); end
      for (int e = 0; e < 2; e++)
        for (int np = 0; np < 2; np++) begin
          stat_ie = e[0]; no_other_pend = np[0]; #1;
          chk(irq_vec, (fl == 1 && e == 1 && np == 1) ? 1 : 0, "R11 vector");
        end
    end

    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule